// File: doc/BRIEF.md
# Square-Wave Output and Reference-Clock Tick Selector

This block sits between a 32.768 kHz timekeeping oscillator and one bidirectional pin. It also supplies the calendar with its once-per-second advance pulse. In internal mode the pin is an output. A free-running phase counter, advanced once per oscillator half-period, drives the pin at one of four selectable rates, or holds it at a programmable static level. In the same mode the counter's wrap produces the one-second tick.

In external mode the pin output driver is released and the pin becomes a reference input. Its rising edges are synchronised into the system clock and counted. A selectable divisor matches the kind of reference in use: a 32 kHz clock, 50 Hz mains, 60 Hz mains, or a one-pulse-per-second signal. Each time the count reaches the divisor, one tick is issued.

Independently of the mode, a watchdog measures how long the oscillator has gone without stepping. When the gap is too long, it raises a sticky stop flag. Software clears that flag by writing zero to it.

Top module: `wave_ref_select`

## Requirements
- R1: With `extMode`=0 the pin is driven (`pinOe`=1). With `extMode`=1 the pin is released (`pinOe`=0) and `pinOut` reads 0.
- R2: `oscTick` pulses once per oscillator half-period, which is 65536 pulses per second. With `outEnable`=1 the wave on `pinOut` follows `rateSel`: 2'b11 → 32.768 kHz (toggles every step), 2'b10 → 8.192 kHz (every 4 steps), 2'b01 → 4.096 kHz (every 8 steps), 2'b00 → 1 Hz (every 32768 steps).
- R3: With `outEnable`=0 in internal mode, `pinOut` holds the level of `idleLevel` and does not toggle.
- R4: In internal mode, `secTick` is a single-cycle pulse issued once per 65536 `oscTick` steps.
- R5: In external mode, `secTick` pulses once per N rising edges of `pinIn`. N is set by `refSel`: 2'b00 → 32768, 2'b01 → 50, 2'b10 → 60, 2'b11 → 1. The internal phase wrap produces no tick in this mode.
- R6: Leaving external mode discards any partial count of reference edges.
- R7: `stopFlag` sets after STOP_LIMIT consecutive clock cycles with no `oscTick`. It does not set after fewer.
- R8: `stopFlag` is sticky. It stays set when ticks resume and when `flagWr` carries `flagWrData`=1. It clears only on `flagWr` with `flagWrData`=0. A set condition in the same cycle as a clear wins.
- R9: During reset, `secTick` is 0 and `stopFlag` is 1.
- R10: `secTick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One pulse per oscillator half-period |
| extMode | input | 1 | 1: pin is a reference input; 0: pin is an output |
| outEnable | input | 1 | 1: output the selected wave; 0: output the static level |
| idleLevel | input | 1 | Static pin level when the wave is disabled |
| rateSel | input | 2 | Output wave rate select |
| refSel | input | 2 | External reference divisor select |
| pinIn | input | 1 | Pin value as seen from the pad |
| flagWr | input | 1 | Write strobe for the stop flag |
| flagWrData | input | 1 | Data written with `flagWr` |
| pinOut | output | 1 | Value driven to the pad |
| pinOe | output | 1 | Pad output enable |
| secTick | output | 1 | One-second advance pulse |
| stopFlag | output | 1 | Sticky oscillator-stop flag |

## Verification
The assertions check every cycle that the tick never lasts two cycles, and that the phase counter only moves on an oscillator step. They also check that an internal-mode tick coincides with a phase of zero, that the stop flag never rises right after a step, and that the flag is not lost without a zero write. Only the bench scenarios can show the actual output rates, the static level, and the per-reference divisor counts. The same holds for the discarded partial count on a mode change and the exact threshold at which the stop flag sets.

// File: rtl/wave_ref_pkg.sv
package wave_ref_pkg;

  typedef struct packed {
    logic oscStep;   // phase counter advances
    logic refRise;   // synchronised rising edge of the reference
    logic refClear;  // discard the partial reference count
  } strobes_t;

  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_32K  = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    REF_32K   = 2'b00,
    REF_MAINA = 2'b01,
    REF_MAINB = 2'b10,
    REF_PPS   = 2'b11
  } ref_e;

endpackage

// File: rtl/wave_ref_ctrl.sv
module wave_ref_ctrl
  import wave_ref_pkg::*;
#(
  parameter int STOP_LIMIT = 3276800
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscTick,
  input  logic     extMode,
  input  logic     pinIn,
  input  logic     flagWr,
  input  logic     flagWrData,
  output strobes_t strobes,
  output logic     stopFlag
);
  localparam int STOP_W = $clog2(STOP_LIMIT + 1);
  localparam logic [STOP_W-1:0] LIMIT_V = STOP_W'(STOP_LIMIT);

  logic [2:0] syncQ;
  logic [STOP_W-1:0] idleCnt;
  logic stopSet;

  // two-flop synchroniser plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], pinIn};
  end

  always_comb begin
    strobes.oscStep  = oscTick;
    strobes.refRise  = extMode & syncQ[1] & ~syncQ[2];
    strobes.refClear = ~extMode;
  end

  // watchdog on oscillator activity, saturating at the limit
  always_ff @(posedge clk) begin
    if (!rstN)                 idleCnt <= '0;
    else if (oscTick)          idleCnt <= '0;
    else if (idleCnt != LIMIT_V) idleCnt <= idleCnt + 1'b1;
  end

  assign stopSet = !oscTick && (idleCnt == LIMIT_V - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                       stopFlag <= 1'b1;
    else if (stopSet)                stopFlag <= 1'b1;
    else if (flagWr && !flagWrData)  stopFlag <= 1'b0;
  end

  // R8: only a zero write can drop the flag
  a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rstN)
    stopFlag && !(flagWr && !flagWrData) |=> stopFlag);

  // R7: a step just seen means the flag cannot rise next
  a_r7_no_set_after_step: assert property (@(posedge clk) disable iff (!rstN)
    oscTick |=> !$rose(stopFlag));

endmodule

// File: rtl/wave_ref_dp.sv
module wave_ref_dp
  import wave_ref_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int DIV_MAINA = 50,
  parameter int DIV_MAINB = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   strobes,
  input  logic       extMode,
  input  logic       outEnable,
  input  logic       idleLevel,
  input  logic [1:0] rateSel,
  input  logic [1:0] refSel,
  output logic       pinOut,
  output logic       pinOe,
  output logic       secTick
);
  localparam int BIT_32K = 0;
  localparam int BIT_8K  = 2;
  localparam int BIT_4K  = 3;
  localparam int BIT_1HZ = PHASE_W - 1;
  localparam logic [PHASE_W-1:0] DIV_HALF = PHASE_W'(1) << (PHASE_W - 1);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] refCnt;
  logic [PHASE_W-1:0] refDiv;
  logic wrap, refHit, wave;

  always_ff @(posedge clk) begin
    if (!rstN)                phase <= '0;
    else if (strobes.oscStep) phase <= phase + 1'b1;
  end

  assign wrap = strobes.oscStep && (&phase);

  always_comb begin
    case (ref_e'(refSel))
      REF_32K:   refDiv = DIV_HALF;
      REF_MAINA: refDiv = PHASE_W'(DIV_MAINA);
      REF_MAINB: refDiv = PHASE_W'(DIV_MAINB);
      default:   refDiv = PHASE_W'(1);
    endcase
  end

  assign refHit = strobes.refRise && (refCnt >= refDiv - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.refClear) refCnt <= '0;
    else if (refHit)               refCnt <= '0;
    else if (strobes.refRise)      refCnt <= refCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) secTick <= 1'b0;
    else       secTick <= extMode ? refHit : wrap;
  end

  always_comb begin
    case (rate_e'(rateSel))
      RATE_32K: wave = phase[BIT_32K];
      RATE_8K:  wave = phase[BIT_8K];
      RATE_4K:  wave = phase[BIT_4K];
      default:  wave = phase[BIT_1HZ];
    endcase
  end

  assign pinOe  = !extMode;
  assign pinOut = extMode ? 1'b0 : (outEnable ? wave : idleLevel);

  // R10: tick is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  // R2: phase moves only on an oscillator step
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.oscStep |=> $stable(phase));

  // R4: an internal tick lands on the wrapped phase
  a_r4_tick_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    secTick && !$past(extMode) |-> phase == '0);

endmodule

// File: rtl/wave_ref_select.sv
module wave_ref_select
  import wave_ref_pkg::*;
#(
  parameter int PHASE_W    = 16,
  parameter int DIV_MAINA  = 50,
  parameter int DIV_MAINB  = 60,
  parameter int STOP_LIMIT = 3276800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       extMode,
  input  logic       outEnable,
  input  logic       idleLevel,
  input  logic [1:0] rateSel,
  input  logic [1:0] refSel,
  input  logic       pinIn,
  input  logic       flagWr,
  input  logic       flagWrData,
  output logic       pinOut,
  output logic       pinOe,
  output logic       secTick,
  output logic       stopFlag
);
  strobes_t strobes;

  wave_ref_ctrl #(.STOP_LIMIT(STOP_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .extMode(extMode),
    .pinIn(pinIn), .flagWr(flagWr), .flagWrData(flagWrData),
    .strobes(strobes), .stopFlag(stopFlag)
  );

  wave_ref_dp #(.PHASE_W(PHASE_W), .DIV_MAINA(DIV_MAINA), .DIV_MAINB(DIV_MAINB)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .extMode(extMode),
    .outEnable(outEnable), .idleLevel(idleLevel), .rateSel(rateSel),
    .refSel(refSel), .pinOut(pinOut), .pinOe(pinOe), .secTick(secTick)
  );

endmodule

// File: tb/test_wave_ref_select.sv
module test_wave_ref_select;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rstN, oscTick, extMode, outEnable, idleLevel, pinIn, flagWr, flagWrData;
  logic [1:0] rateSel, refSel;
  logic pinOut, pinOe, secTick, stopFlag;

  int total = 0, bad = 0, ticksSeen = 0, consec = 0, cycles = 0;
  logic prevSec = 1'b0;

  always #4 clk = ~clk;

  wave_ref_select #(.STOP_LIMIT(LIMIT)) i_wave_ref_select (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .extMode(extMode),
    .outEnable(outEnable), .idleLevel(idleLevel), .rateSel(rateSel),
    .refSel(refSel), .pinIn(pinIn), .flagWr(flagWr), .flagWrData(flagWrData),
    .pinOut(pinOut), .pinOe(pinOe), .secTick(secTick), .stopFlag(stopFlag)
  );

  // {ext, en, idle, rate[1:0], toggles[6:0], expOe, chkLevel, expLevel, pad}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 2'b11, 7'd64, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 2'b10, 7'd16, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 2'b01, 7'd8,  1'b1, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 2'b11, 7'd0,  1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 2'b10, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 2'b11, 7'd0,  1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (secTick) ticksSeen++;
    if (secTick && prevSec) consec++;
    prevSec = secTick;
  endtask

  task automatic refEdges(input int n, input int hi, input int lo);
    for (int e = 0; e < n; e++) begin
      pinIn = 1'b1;
      for (int h = 0; h < hi; h++) step();
      pinIn = 1'b0;
      for (int l = 0; l < lo; l++) step();
    end
    for (int k = 0; k < 10; k++) step();
  endtask

  task automatic reEnterExt(input logic [1:0] sel);
    extMode = 1'b0;
    step(); step();
    refSel = sel;
    extMode = 1'b1;
    ticksSeen = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; oscTick = 1'b1; extMode = 1'b0; outEnable = 1'b1;
    idleLevel = 1'b0; rateSel = 2'b11; refSel = 2'b11; pinIn = 1'b0;
    flagWr = 1'b0; flagWrData = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 reset tick", int'(secTick), 0);
    check("R9 reset flag", int'(stopFlag), 1);
    check("R1 reset oe", int'(pinOe), 1);
    rstN = 1'b1;
    step();
    check("R8 flag survives after reset", int'(stopFlag), 1);
    flagWr = 1'b1; flagWrData = 1'b0;
    step();
    flagWr = 1'b0;
    check("R8 zero write clears", int'(stopFlag), 0);

    // table of output configurations
    for (int v = 0; v < 6; v++) begin
      logic prev;
      int tog;
      {extMode, outEnable, idleLevel, rateSel} = VEC[v][15:11];
      repeat (4) step();
      prev = pinOut;
      tog = 0;
      for (int s = 0; s < 64; s++) begin
        step();
        if (pinOut != prev) tog++;
        prev = pinOut;
      end
      check($sformatf("R2/R3 toggles vec%0d", v), tog, int'(VEC[v][10:4]));
      check($sformatf("R1 oe vec%0d", v), int'(pinOe), int'(VEC[v][3]));
      if (VEC[v][2]) check($sformatf("R3/R1 level vec%0d", v), int'(pinOut), int'(VEC[v][1]));
    end

    // 1 Hz wave and internal second tick
    begin
      logic prev;
      int tog;
      extMode = 1'b0; outEnable = 1'b1; rateSel = 2'b00;
      step();
      prev = pinOut; tog = 0; ticksSeen = 0;
      for (int s = 0; s < 65536; s++) begin
        step();
        if (pinOut != prev) tog++;
        prev = pinOut;
      end
      check("R2 1Hz toggles", tog, 2);
      check("R4 internal ticks", ticksSeen, 1);
    end

    // external references
    reEnterExt(2'b11);
    refEdges(5, 2, 2);
    check("R5 pps divisor", ticksSeen, 5);
    reEnterExt(2'b01);
    refEdges(100, 2, 2);
    check("R5 mains50 divisor", ticksSeen, 2);
    reEnterExt(2'b10);
    refEdges(120, 3, 5);
    check("R5 mains60 divisor", ticksSeen, 2);
    reEnterExt(2'b00);
    refEdges(32768, 1, 1);
    check("R5 32k divisor, no wrap tick", ticksSeen, 1);

    // R6: partial count discarded when leaving external mode
    reEnterExt(2'b01);
    refEdges(30, 2, 2);
    check("R6 partial count no tick", ticksSeen, 0);
    reEnterExt(2'b01);
    refEdges(70, 2, 2);
    check("R6 count restarted", ticksSeen, 1);
    extMode = 1'b0;
    step();

    // R7: stop detection threshold
    oscTick = 1'b0;
    repeat (30) step();
    check("R7 short gap", int'(stopFlag), 0);
    oscTick = 1'b1; step();
    oscTick = 1'b0;
    repeat (LIMIT - 1) step();
    check("R7 one below limit", int'(stopFlag), 0);
    step();
    check("R7 at limit", int'(stopFlag), 1);

    // R8: stickiness
    oscTick = 1'b1;
    repeat (5) step();
    check("R8 holds with ticks", int'(stopFlag), 1);
    flagWr = 1'b1; flagWrData = 1'b1;
    step();
    check("R8 one write ignored", int'(stopFlag), 1);
    flagWrData = 1'b0;
    step();
    flagWr = 1'b0;
    check("R8 zero write clears", int'(stopFlag), 0);
    oscTick = 1'b0;
    repeat (LIMIT - 1) step();
    flagWr = 1'b1; flagWrData = 1'b0;
    step();
    flagWr = 1'b0;
    check("R8 set beats clear", int'(stopFlag), 1);
    oscTick = 1'b1;
    step();

    check("R10 no back-to-back ticks", consec, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule